// File: doc/BRIEF.md
# Multi-Core Shared GPIO Combiner

This block lets eight processor cores share one bank of 32 general-purpose pins. Each core owns a private direction register and a private output register, written through its own write port as full 32-bit words and read back through its own read port. From the set of cores currently marked active, the block works out for every pin whether it is driven and at what level. It then presents the result as pad output-enable and pad output-value signals for a tri-state pad ring.

A pin is driven when at least one active core has marked it as an output. The driven level is the OR of the output bits of every active core that drives that pin. Pad levels pass through a two-flop synchronizer, and the synchronized word is returned to every core's input register at once, whatever each pin's direction. A core-active mask switches whole cores in and out of the vote without disturbing their stored registers.

Top module: `gpio_share_top`

## Requirements
- R1: After reset, every core's direction and output registers read 0, `pad_oe_o` is 0 on all pins, and every core's input word reads 0.
- R2: A write strobe for a core loads that core's register with its full 32-bit write word on the clock edge, and the pads reflect it only after that edge.
- R3: A pin's output enable is 1 when any active core has a 1 in that pin's direction bit (1 = output, 0 = input), and 0 otherwise.
- R4: A core's output bit for a pin has no effect on `pad_out_o` while that core's direction bit for the pin is 0.
- R5: Where several active cores drive a pin, the pin is 1 if any of them drives 1 and 0 only if all of them drive 0.
- R6: A core whose bit in `core_active_i` is 0 contributes neither direction nor output bits. Its stored registers are kept and count again once the core is reactivated.
- R7: `pad_out_o` is 0 on every pin whose output enable is 0.
- R8: A level on `pad_in_i` appears in every core's input word after exactly two clock edges, regardless of pin direction.
- R9: A write to one core's registers leaves every other core's registers unchanged.
- R10: Raising both write strobes of a core in the same cycle loads the same word into both its direction and output registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_active_i | input | 8 | One bit per core; 1 means the core takes part in the vote |
| dir_we_i | input | 8 | Per-core direction register write strobe |
| out_we_i | input | 8 | Per-core output register write strobe |
| wdata_i | input | 8x32 | Per-core write word, core c at bits [32c+31:32c] |
| dir_rdata_o | output | 8x32 | Per-core direction register readback |
| out_rdata_o | output | 8x32 | Per-core output register readback |
| in_rdata_o | output | 8x32 | Per-core input word (synchronized pad levels) |
| pad_in_i | input | 32 | Pad input levels |
| pad_oe_o | output | 32 | Pad output enable, 1 = driven |
| pad_out_o | output | 32 | Pad output value |

## Verification
The vote is tried first with a single driving core, where enables follow that core's direction word and output bits on its input pins must vanish. It is then tried with overlapping drivers, where some pins see a 1 from only one core and others see 0 from every core, which separates OR voting from last-writer or AND behaviour. Masking cores off and then back on shows that activity gates the vote without clearing stored state, and an all-zero mask must release every pin. A pad word applied while pins are driven is checked one edge later, still hidden, and two edges later, present in every core, which pins down the synchronizer depth.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
  parameter int unsigned NUM_CORES = 8;
  parameter int unsigned NUM_PINS  = 32;
  parameter int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/gpio_core_regs.sv
module gpio_core_regs #(
  parameter int unsigned NP = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dir_we_i,
  input  logic          out_we_i,
  input  logic [NP-1:0] wdata_i,
  output logic [NP-1:0] dir_o,
  output logic [NP-1:0] out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      out_o <= '0;
    end else begin
      if (dir_we_i) dir_o <= wdata_i;
      if (out_we_i) out_o <= wdata_i;
    end
  end

  p_dir_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> dir_o == $past(wdata_i));
  p_out_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_we_i |=> out_o == $past(wdata_i));
  p_dir_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_we_i |=> $stable(dir_o));
  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_we_i |=> $stable(out_o));
endmodule

// File: rtl/gpio_pin_vote.sv
module gpio_pin_vote #(
  parameter int unsigned NC = 8,
  parameter int unsigned NP = 32
) (
  input  logic [NC-1:0]         active_i,
  input  logic [NC-1:0][NP-1:0] dir_i,
  input  logic [NC-1:0][NP-1:0] out_i,
  output logic [NP-1:0]         oe_o,
  output logic [NP-1:0]         lvl_o
);
  always_comb begin
    oe_o  = '0;
    lvl_o = '0;
    for (int c = 0; c < NC; c++) begin
      if (active_i[c]) begin
        oe_o  = oe_o  | dir_i[c];
        lvl_o = lvl_o | (dir_i[c] & out_i[c]);
      end
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NP    = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NP-1:0] pad_i,
  output logic [NP-1:0] sync_o
);
  logic [DEPTH-1:0][NP-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else begin
      stage_q[0] <= pad_i;
      for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
    end
  end
  assign sync_o = stage_q[DEPTH-1];

  // cycles since reset, saturating, so $past stays inside valid history
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  if (DEPTH == 2) begin : g_chk
    p_sync_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      age_q == 2'd2 |-> sync_o == $past(pad_i, 2));
  end
endmodule

// File: rtl/gpio_share_top.sv
module gpio_share_top
  import gpio_share_pkg::*;
#(
  parameter int unsigned NC = NUM_CORES,
  parameter int unsigned NP = NUM_PINS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NC-1:0]         core_active_i,
  input  logic [NC-1:0]         dir_we_i,
  input  logic [NC-1:0]         out_we_i,
  input  logic [NC-1:0][NP-1:0] wdata_i,
  output logic [NC-1:0][NP-1:0] dir_rdata_o,
  output logic [NC-1:0][NP-1:0] out_rdata_o,
  output logic [NC-1:0][NP-1:0] in_rdata_o,
  input  logic [NP-1:0]         pad_in_i,
  output logic [NP-1:0]         pad_oe_o,
  output logic [NP-1:0]         pad_out_o
);
  logic [NP-1:0] in_sync;

  for (genvar c = 0; c < NC; c++) begin : g_core
    gpio_core_regs #(.NP(NP)) regs_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .dir_we_i (dir_we_i[c]),
      .out_we_i (out_we_i[c]),
      .wdata_i  (wdata_i[c]),
      .dir_o    (dir_rdata_o[c]),
      .out_o    (out_rdata_o[c])
    );
    assign in_rdata_o[c] = in_sync;
  end

  gpio_pin_vote #(.NC(NC), .NP(NP)) vote_i (
    .active_i (core_active_i),
    .dir_i    (dir_rdata_o),
    .out_i    (out_rdata_o),
    .oe_o     (pad_oe_o),
    .lvl_o    (pad_out_o)
  );

  gpio_in_sync #(.NP(NP), .DEPTH(SYNC_DEPTH)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pad_i  (pad_in_i),
    .sync_o (in_sync)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i)
    !rst_ni |-> pad_oe_o == '0);
  p_undriven_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);
  p_no_active_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_active_i == '0 |-> pad_oe_o == '0);
  p_no_write_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_we_i == '0 && out_we_i == '0 && $stable(core_active_i)) |=> $stable(pad_oe_o));
endmodule

// File: tb/gpio_share_top_tb_top.sv
`timescale 1ns/1ps
module gpio_share_top_tb_top;
  localparam int NC = 8;
  localparam int NP = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NC-1:0] core_active = '1;
  logic [NC-1:0] dir_we = '0;
  logic [NC-1:0] out_we = '0;
  logic [NC-1:0][NP-1:0] wdata = '0;
  logic [NC-1:0][NP-1:0] dir_rd, out_rd, in_rd;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_share_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .core_active_i(core_active),
    .dir_we_i(dir_we), .out_we_i(out_we), .wdata_i(wdata),
    .dir_rdata_o(dir_rd), .out_rdata_o(out_rd), .in_rdata_o(in_rd),
    .pad_in_i(pad_in), .pad_oe_o(pad_oe), .pad_out_o(pad_out)
  );

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int c, input logic d, input logic o, input logic [NP-1:0] v);
    @(negedge clk);
    dir_we[c] = d; out_we[c] = o; wdata[c] = v;
    @(negedge clk);
    dir_we[c] = 1'b0; out_we[c] = 1'b0;
  endtask

  task automatic t_reset;
    for (int c = 0; c < NC; c++) begin
      chk("R1 dir", dir_rd[c], '0);
      chk("R1 out", out_rd[c], '0);
      chk("R1 in", in_rd[c], '0);
    end
    chk("R1 oe", pad_oe, '0);
  endtask

  task automatic t_single;
    wr(0, 1'b0, 1'b1, 32'hA5A5_0F0F);
    chk("R4 out only", pad_oe, '0);
    chk("R4 no drive", pad_out, '0);
    @(negedge clk);
    dir_we[0] = 1'b1; wdata[0] = 32'h0000_FFFF;
    #1 chk("R2 before edge", pad_oe, '0);
    @(negedge clk);
    dir_we[0] = 1'b0;
    chk("R2 dir rd", dir_rd[0], 32'h0000_FFFF);
    chk("R3 oe", pad_oe, 32'h0000_FFFF);
    chk("R7 out", pad_out, 32'h0000_0F0F);
  endtask

  task automatic t_wired_or;
    wr(1, 1'b1, 1'b0, 32'h0000_00FF);
    wr(1, 1'b0, 1'b1, 32'hFFFF_FFF0);
    wr(2, 1'b1, 1'b0, 32'hFFFF_0000);
    chk("R5 oe", pad_oe, 32'hFFFF_FFFF);
    chk("R5 wired or", pad_out, 32'h0000_0FFF);
  endtask

  task automatic t_inactive;
    @(negedge clk); core_active = 8'b1111_1110;
    #1;
    chk("R6 oe masked", pad_oe, 32'hFFFF_00FF);
    chk("R6 out masked", pad_out, 32'h0000_00F0);
    core_active = 8'h00; #1;
    chk("R6 none oe", pad_oe, '0);
    chk("R7 none out", pad_out, '0);
    core_active = 8'hFF; #1;
    chk("R6 back oe", pad_oe, 32'hFFFF_FFFF);
    chk("R6 back out", pad_out, 32'h0000_0FFF);
  endtask

  task automatic t_indep;
    chk("R9 core0 dir", dir_rd[0], 32'h0000_FFFF);
    chk("R9 core0 out", out_rd[0], 32'hA5A5_0F0F);
    chk("R9 core3 dir", dir_rd[3], '0);
    chk("R9 core3 out", out_rd[3], '0);
  endtask

  task automatic t_both;
    wr(4, 1'b1, 1'b1, 32'h8000_0001);
    chk("R10 dir", dir_rd[4], 32'h8000_0001);
    chk("R10 out", out_rd[4], 32'h8000_0001);
    chk("R10 pad", pad_out, 32'h8000_0FFF);
  endtask

  task automatic t_sync;
    @(negedge clk); pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    for (int c = 0; c < NC; c++) chk("R8 one edge", in_rd[c], '0);
    @(negedge clk);
    for (int c = 0; c < NC; c++) chk("R8 two edges", in_rd[c], 32'hDEAD_BEEF);
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_single();
    t_wired_or();
    t_inactive();
    t_indep();
    t_both();
    t_sync();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule